// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a 32-bit effective address through a hashed page table held in memory. A caller supplies the effective address, the segment register chosen for that address, the table base/size register, the privilege mode and the access kind (load or store), then pulses `start`. The walker forms the address of a 64-byte page group from an XOR hash of the segment's virtual segment identifier and the page index. It reads the group's entries one pair at a time over a single-outstanding 32-bit memory port and compares each entry's tag word with a compare word built from the same inputs.

If the primary group holds no matching tag, the walker repeats the search in the secondary group, whose hash is the bitwise complement of the primary one. On a match it reads the entry's second word, forms the real address, and decodes read and write rights from the entry's two protection bits and the segment's privilege keys. It then marks the entry as used and, for a permitted store, as modified, by writing single bytes. A one-cycle `done` pulse reports hit, protection fault or miss. The result, real address and rights stay on the outputs until the next `start`.

Top module: `hpt_walker`

## Requirements
- R1: The primary group address is `{tbl[31:16],16'h0} | (H & M)`. Here H = `({8'h0, seg[23:0] ^ {8'h0, ea[27:12]}}) << 6`, truncated to 32 bits, and M = `{7'h0, tbl[8:0], 16'hFFC0}`. Pair k has its tag word at group+8k and its data word at group+8k+4.
- R2: The compare word is `{1'b1, seg[23:0], S, ea[27:22]}`, where S is 0 in the primary search and 1 in the secondary. A tag matches only when it equals this word exactly.
- R3: The secondary search uses `~H` in place of H and runs only when no tag in the primary group matched. A primary match that lacks the needed right ends in a fault without a secondary search.
- R4: Within a group, pairs are examined in ascending order and the lowest-numbered matching pair is used.
- R5: On a hit or fault, `real_addr` is the data word with bits 11:0 replaced by `ea[11:0]`. On a miss it is zero.
- R6: The protection index is `{key, data[1:0]}`, where key is `seg[29]` in user mode and `seg[30]` in supervisor mode. Indices 0, 1, 2 and 6 grant read and write. Indices 3, 5 and 7 grant read only. Index 4 grants nothing. Execute is granted whenever an entry was found.
- R7: When the found entry is readable and data bit 8 (referenced) is clear, the walker writes the data word's address with byte-enable `4'b0010` (bits 15:8), and the written lane has bit 8 set.
- R8: When the access is a store that the entry permits and data bit 7 (changed) is clear, the walker writes byte-enable `4'b0001` (bits 7:0) with bit 7 set. A bit that is already set causes no write.
- R9: `done` is high for exactly one cycle per walk, and `result` then reads 1 for hit, 2 for fault or 3 for miss. A load needs read rights and a store needs write rights, otherwise the result is a fault. `result` and the translation outputs hold until the next `start`.
- R10: A memory request is held, with unchanged address and kind, until `mem_req_ready`. No request is issued while the walker is idle, and a read's data is taken from the cycle in which `mem_rsp_valid` is high.
- R11: Table size bits `tbl[8:0]` widen the hash mask, so that hash bits 24:16 select among larger tables.
- R12: After reset, `busy`, `done` and `mem_req_valid` are low and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| ea | input | 32 | Effective address |
| seg | input | 32 | Segment register: keys in bits 30/29, VSID in 23:0 |
| tbl | input | 32 | Table base (31:16) and size mask (8:0) |
| user_mode | input | 1 | 1 for user, 0 for supervisor |
| is_store | input | 1 | 1 for a store access |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 for a byte write |
| mem_req_addr | output | 32 | Word byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_req_be | output | 4 | Byte lane enables, bit n covers bits 8n+7:8n |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 none, 1 hit, 2 fault, 3 miss |
| real_addr | output | 32 | Translated address |
| may_read | output | 1 | Read granted |
| may_write | output | 1 | Write granted |
| may_exec | output | 1 | Execute granted |

## Verification
The bench sweeps every protection index against both privilege modes and both access kinds. It places the entry in either group, at every pair slot, with the two tables sizes, and with the referenced and changed bits preset or clear. An inverted key select or a wrong index decode would give the wrong rights. A missing complement, or a missing bit 6 in the compare word, would turn secondary hits into misses. Directed cases cover two matching pairs in one group, where a design that did not stop at the first match would return the later frame, and a faulting primary match beside a writable secondary entry, where a design that searched on would report a hit. The memory model stalls requests at random and counts byte writes, so that an update written to the wrong lane, a redundant write or a changed address under stall shows up at the ports.

// File: rtl/hptw_pkg.sv
package hptw_pkg;
    localparam int VSID_W = 24;
    localparam int PAGE_W = 16;
    localparam logic [31:0] REF_MASK = 32'h0000_0100;
    localparam logic [31:0] CHG_MASK = 32'h0000_0080;
    localparam logic [3:0]  REF_LANE = 4'b0010;
    localparam logic [3:0]  CHG_LANE = 4'b0001;

    typedef enum logic [2:0] {
        S_IDLE, S_TAG_REQ, S_TAG_WAIT, S_DAT_REQ, S_DAT_WAIT, S_SET_REF, S_SET_CHG
    } walk_st_e;

    typedef enum logic [1:0] {
        RES_NONE = 2'd0, RES_HIT = 2'd1, RES_FAULT = 2'd2, RES_MISS = 2'd3
    } walk_res_e;
endpackage

// File: rtl/hptw_hash.sv
module hptw_hash
    import hptw_pkg::*;
(
    input  logic [31:0] ea,
    input  logic [31:0] seg,
    input  logic [31:0] tbl,
    input  logic        sec,
    output logic [31:0] grp_addr,
    output logic [31:0] cmp_word
);
    logic [VSID_W-1:0] mix;
    logic [31:0]       raw;
    logic [31:0]       sel;
    logic [31:0]       mask;

    always_comb begin
        mix      = seg[VSID_W-1:0] ^ {{(VSID_W-PAGE_W){1'b0}}, ea[27:12]};
        raw      = {{(32-VSID_W){1'b0}}, mix} << 6;
        sel      = sec ? ~raw : raw;
        mask     = {7'b0, tbl[8:0], 16'hFFC0};
        grp_addr = {tbl[31:16], 16'h0000} | (sel & mask);
        cmp_word = {1'b1, seg[VSID_W-1:0], sec, ea[27:22]};
    end
endmodule

// File: rtl/hptw_perm.sv
module hptw_perm (
    input  logic [1:0] pp,
    input  logic       key,
    output logic       rd,
    output logic       wr
);
    logic [2:0] idx;

    always_comb begin
        idx = {key, pp};
        rd  = 1'b0;
        wr  = 1'b0;
        case (idx)
            3'd0, 3'd1, 3'd2, 3'd6: begin rd = 1'b1; wr = 1'b1; end
            3'd3, 3'd5, 3'd7:       begin rd = 1'b1; end
            default:                begin end
        endcase
    end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hptw_pkg::*;
#(
    parameter int NUM_PAIRS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] ea,
    input  logic [31:0] seg,
    input  logic [31:0] tbl,
    input  logic        user_mode,
    input  logic        is_store,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic        mem_req_we,
    output logic [31:0] mem_req_addr,
    output logic [31:0] mem_req_wdata,
    output logic [3:0]  mem_req_be,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_rdata,
    output logic        busy,
    output logic        done,
    output logic [1:0]  result,
    output logic [31:0] real_addr,
    output logic        may_read,
    output logic        may_write,
    output logic        may_exec
);
    localparam int IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PAIRS - 1);

    typedef struct packed {
        walk_st_e         st;
        logic [IDX_W-1:0] idx;
        logic             sec;
        logic [31:0]      ea;
        logic [31:0]      seg;
        logic [31:0]      tbl;
        logic             user;
        logic             store;
        logic [31:0]      dat;
        logic             prd;
        logic             pwr;
        walk_res_e        res;
        logic             done;
    } walk_s;

    walk_s q, d;

    logic [31:0] grp_addr, cmp_word, tag_addr, dat_addr;
    logic        key, p_rd, p_wr;

    hptw_hash u_hash (
        .ea       (q.ea),
        .seg      (q.seg),
        .tbl      (q.tbl),
        .sec      (q.sec),
        .grp_addr (grp_addr),
        .cmp_word (cmp_word)
    );

    assign key = q.user ? q.seg[29] : q.seg[30];

    hptw_perm u_perm (
        .pp  (mem_rsp_rdata[1:0]),
        .key (key),
        .rd  (p_rd),
        .wr  (p_wr)
    );

    function automatic walk_res_e verdict(input logic rd, input logic wr, input logic store);
        return (!rd || (store && !wr)) ? RES_FAULT : RES_HIT;
    endfunction

    always_comb begin
        d             = q;
        d.done        = 1'b0;
        tag_addr      = grp_addr + {{(29-IDX_W){1'b0}}, q.idx, 3'b000};
        dat_addr      = tag_addr + 32'd4;
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = 32'h0;
        mem_req_wdata = 32'h0;
        mem_req_be    = 4'h0;

        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.st    = S_TAG_REQ;
                    d.idx   = '0;
                    d.sec   = 1'b0;
                    d.ea    = ea;
                    d.seg   = seg;
                    d.tbl   = tbl;
                    d.user  = user_mode;
                    d.store = is_store;
                    d.res   = RES_NONE;
                    d.prd   = 1'b0;
                    d.pwr   = 1'b0;
                    d.dat   = 32'h0;
                end
            end
            S_TAG_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = tag_addr;
                if (mem_req_ready) d.st = S_TAG_WAIT;
            end
            S_TAG_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_rdata == cmp_word) begin
                        d.st = S_DAT_REQ;
                    end else if (q.idx != LAST_IDX) begin
                        d.idx = q.idx + 1'b1;
                        d.st  = S_TAG_REQ;
                    end else if (!q.sec) begin
                        d.sec = 1'b1;
                        d.idx = '0;
                        d.st  = S_TAG_REQ;
                    end else begin
                        d.res  = RES_MISS;
                        d.done = 1'b1;
                        d.st   = S_IDLE;
                    end
                end
            end
            S_DAT_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = dat_addr;
                if (mem_req_ready) d.st = S_DAT_WAIT;
            end
            S_DAT_WAIT: begin
                if (mem_rsp_valid) begin
                    d.dat = mem_rsp_rdata;
                    d.prd = p_rd;
                    d.pwr = p_wr;
                    if (p_rd && ((mem_rsp_rdata & REF_MASK) == 32'h0)) begin
                        d.st = S_SET_REF;
                    end else if (q.store && p_wr && ((mem_rsp_rdata & CHG_MASK) == 32'h0)) begin
                        d.st = S_SET_CHG;
                    end else begin
                        d.res  = verdict(p_rd, p_wr, q.store);
                        d.done = 1'b1;
                        d.st   = S_IDLE;
                    end
                end
            end
            S_SET_REF: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = dat_addr;
                mem_req_wdata = q.dat | REF_MASK;
                mem_req_be    = REF_LANE;
                if (mem_req_ready) begin
                    d.dat = q.dat | REF_MASK;
                    if (q.store && q.pwr && ((q.dat & CHG_MASK) == 32'h0)) begin
                        d.st = S_SET_CHG;
                    end else begin
                        d.res  = verdict(q.prd, q.pwr, q.store);
                        d.done = 1'b1;
                        d.st   = S_IDLE;
                    end
                end
            end
            S_SET_CHG: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = dat_addr;
                mem_req_wdata = q.dat | CHG_MASK;
                mem_req_be    = CHG_LANE;
                if (mem_req_ready) begin
                    d.dat  = q.dat | CHG_MASK;
                    d.res  = verdict(q.prd, q.pwr, q.store);
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic found;
    assign found     = (q.res == RES_HIT) || (q.res == RES_FAULT);
    assign busy      = (q.st != S_IDLE);
    assign done      = q.done;
    assign result    = q.res;
    assign real_addr = found ? {q.dat[31:12], q.ea[11:0]} : 32'h0;
    assign may_read  = found && q.prd;
    assign may_write = found && q.pwr;
    assign may_exec  = found;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we))); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid); // R10
    AST_WR_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> (mem_req_be == REF_LANE || mem_req_be == CHG_LANE)); // R7
    AST_CHG_ONLY_PERMITTED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we && mem_req_be == CHG_LANE) |-> (q.store && q.pwr)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != 2'd0)); // R9
    AST_WRITE_IMPLIES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        may_write |-> may_read); // R6
endmodule

// File: tb/hpt_walker_tb.sv
module hpt_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ea = '0, seg = '0, tbl = '0;
    logic        user_mode = 1'b0, is_store = 1'b0;
    logic        mem_req_valid, mem_req_we, mem_req_ready;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic [3:0]  mem_req_be;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_rdata;
    logic        busy, done, may_read, may_write, may_exec;
    logic [1:0]  result;
    logic [31:0] real_addr;

    int total = 0;
    int bad = 0;
    int wr_cnt = 0;
    int hold_viol = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hpt_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .seg(seg), .tbl(tbl),
        .user_mode(user_mode), .is_store(is_store),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .busy(busy), .done(done), .result(result), .real_addr(real_addr),
        .may_read(may_read), .may_write(may_write), .may_exec(may_exec)
    );

    logic [31:0] mem [0:32767];
    logic [7:0]  lfsr = 8'h5A;
    logic        prev_stall = 1'b0;
    logic [31:0] prev_addr = '0;
    logic        prev_we = 1'b0;

    assign mem_req_ready = (lfsr[1:0] != 2'b00);

    function automatic int midx(input logic [31:0] a);
        return int'(a[16:2]);
    endfunction

    always @(posedge clk) begin
        lfsr          <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_req_be[b]) mem[midx(mem_req_addr)][8*b +: 8] <= mem_req_wdata[8*b +: 8];
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= mem[midx(mem_req_addr)];
            end
        end
        if (prev_stall && (!mem_req_valid || mem_req_addr != prev_addr || mem_req_we != prev_we))
            hold_viol <= hold_viol + 1;
        prev_stall <= mem_req_valid && !mem_req_ready;
        prev_addr  <= mem_req_addr;
        prev_we    <= mem_req_we;
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] grp_of(input logic [31:0] a, input logic [31:0] s,
                                           input logic [31:0] t, input bit sec);
        logic [31:0] h;
        h = (((s & 32'h00FF_FFFF) ^ ((a >> 12) & 32'h0000_FFFF)) << 6);
        if (sec) h = ~h;
        h = h & (((t & 32'h1FF) << 16) | 32'h0000_FFC0);
        return (t & 32'hFFFF_0000) | h;
    endfunction

    function automatic logic [31:0] cmp_of(input logic [31:0] a, input logic [31:0] s, input bit sec);
        return 32'h8000_0000 | ((s & 32'h00FF_FFFF) << 7) | (sec ? 32'h40 : 32'h0) | ((a >> 22) & 32'h3F);
    endfunction

    task automatic clear_groups(input logic [31:0] a, input logic [31:0] s, input logic [31:0] t);
        for (int sc = 0; sc < 2; sc++)
            for (int w = 0; w < 16; w++)
                mem[midx(grp_of(a, s, t, sc[0]) + 32'(4*w))] = 32'h0;
    endtask

    task automatic put_entry(input logic [31:0] a, input logic [31:0] s, input logic [31:0] t,
                             input bit sec, input int slot, input logic [31:0] tag, input logic [31:0] dat);
        logic [31:0] g;
        g = grp_of(a, s, t, sec) + 32'(8*slot);
        mem[midx(g)]     = tag;
        mem[midx(g + 4)] = dat;
    endtask

    // Runs one walk, computing the expected outcome from the requirements.
    task automatic run_case(input logic [31:0] a, input logic [31:0] s, input logic [31:0] t,
                            input bit usr, input bit st, input string tag);
        bit          fnd = 0;
        logic [31:0] daddr = '0, dat = '0, exp_dat, exp_ra;
        bit          key, rd, wr;
        logic [2:0]  pidx;
        logic [1:0]  exp_res;
        int          exp_w, w0;
        for (int sc = 0; sc < 2 && !fnd; sc++)
            for (int i = 0; i < 8 && !fnd; i++)
                if (mem[midx(grp_of(a, s, t, sc[0]) + 32'(8*i))] == cmp_of(a, s, sc[0])) begin
                    fnd   = 1;
                    daddr = grp_of(a, s, t, sc[0]) + 32'(8*i + 4);
                    dat   = mem[midx(daddr)];
                end
        key  = usr ? s[29] : s[30];
        pidx = {key, dat[1:0]};
        wr   = (pidx == 0 || pidx == 1 || pidx == 2 || pidx == 6);
        rd   = wr || pidx == 3 || pidx == 5 || pidx == 7;
        exp_dat = dat | (rd ? 32'h100 : 32'h0) | ((st && wr) ? 32'h80 : 32'h0);
        exp_w   = ((rd && !dat[8]) ? 1 : 0) + ((st && wr && !dat[7]) ? 1 : 0);
        if (!fnd) begin
            exp_res = 2'd3; rd = 0; wr = 0; exp_ra = 32'h0; exp_w = 0;
        end else begin
            exp_res = (!rd || (st && !wr)) ? 2'd2 : 2'd1;
            exp_ra  = {dat[31:12], a[11:0]};
        end
        w0 = wr_cnt;
        @(negedge clk);
        ea = a; seg = s; tbl = t; user_mode = usr; is_store = st; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        chk({tag, " R9"}, "result", 32'(result), 32'(exp_res));
        chk("R5", "real_addr", real_addr, exp_ra);
        chk("R6", "may_read", 32'(may_read), 32'(rd));
        chk("R6", "may_write", 32'(may_write), 32'(wr));
        chk("R6", "may_exec", 32'(may_exec), 32'(fnd));
        @(negedge clk);
        chk("R7/R8", "byte write count", 32'(wr_cnt - w0), 32'(exp_w));
        if (fnd) chk("R7/R8", "data word after", mem[midx(daddr)], exp_dat);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, s, t, tg, dt;
        for (int i = 0; i < 32768; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12", "busy", 32'(busy), 0);
        chk("R12", "done", 32'(done), 0);
        chk("R12", "req_valid", 32'(mem_req_valid), 0);
        chk("R12", "result", 32'(result), 0);
        rst_n = 1'b1;

        // Sweep: R1 R2 R6 R7 R8 R11 over index, keys, mode, access, slot, group, size
        for (int c = 0; c < 128; c++) begin
            bit sec;
            a   = 32'h1234_5678 ^ (32'(c) * 32'h0101_3043);
            s   = {1'b0, c[2], c[3], 5'b0, 24'h0A5300 + 24'(c * 7717)};
            t   = c[6] ? 32'h0020_0001 : 32'h0020_0000;
            sec = c[0] ^ c[5];
            clear_groups(a, s, t);
            for (int k = 0; k < 8; k++) put_entry(a, s, t, sec, k, cmp_of(a, s, sec) ^ 32'h1, 32'hFFFF_FFFF);
            dt = (32'(c * 7919 + 3) << 12) | (c % 3 == 0 ? 32'h100 : 32'h0) | (c % 5 == 0 ? 32'h80 : 32'h0) | 32'(c[1:0]);
            put_entry(a, s, t, sec, (c / 4) % 8, cmp_of(a, s, sec), dt);
            run_case(a, s, t, c[4], c[5], sec ? "R3" : "R1");
            if (c[6]) chk("R11", "hit with sized table", 32'(result != 2'd3), 1);
        end

        // R2: tag in secondary group without bit 6 must not match -> miss
        a = 32'h0ABC_D123; s = 32'h0000_4321; t = 32'h0020_0000;
        clear_groups(a, s, t);
        put_entry(a, s, t, 1, 3, cmp_of(a, s, 0), 32'h0005_5000);
        run_case(a, s, t, 0, 0, "R2");
        chk("R2", "miss", 32'(result), 3);

        // R4: two matching pairs, first one wins
        a = 32'h3456_7ABC; s = 32'h0000_1111;
        clear_groups(a, s, t);
        put_entry(a, s, t, 0, 2, cmp_of(a, s, 0), 32'h000A_A102);
        put_entry(a, s, t, 0, 5, cmp_of(a, s, 0), 32'h000B_B102);
        run_case(a, s, t, 0, 0, "R4");
        chk("R4", "first frame", real_addr, 32'h000A_AABC);

        // R3: faulting primary match does not search secondary
        a = 32'h0765_4321; s = 32'h4000_2222;
        clear_groups(a, s, t);
        put_entry(a, s, t, 0, 1, cmp_of(a, s, 0), 32'h0001_2100);
        put_entry(a, s, t, 1, 0, cmp_of(a, s, 1), 32'h0003_4102);
        run_case(a, s, t, 0, 1, "R3");
        chk("R3", "fault kept", 32'(result), 2);

        // R9: result held after done, done is a single pulse
        repeat (5) @(negedge clk);
        chk("R9", "done low", 32'(done), 0);
        chk("R9", "result held", 32'(result), 2);

        // Empty table miss
        a = 32'h0FFF_FFFF; s = 32'h00FF_FFFF;
        clear_groups(a, s, t);
        run_case(a, s, t, 1, 1, "R9");

        chk("R10", "request hold violations", 32'(hold_viol), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule